// File: doc/BRIEF.md
# System Control Register Bank

This block is a word-addressed bank of 32-bit control registers for a small system-on-chip. It holds the GPIO registers (sampled pin inputs, driven pin outputs, and a per-pin interrupt enable handed to separate interrupt logic), a configuration-port command register, a debug scratchpad, a sticky debug write-lock flag, and three read-only constants: clock frequency, capability bits and a system identifier. Two timer channels own fixed windows of the address map. Their internals live outside the bank, which only forwards write strobes and sub-register selects and multiplexes their read data.

Some writes have side effects. A command word whose low 16 bits match the shutdown code raises a one-cycle shutdown request. Any write to the identifier register leaves it unchanged and raises a one-cycle system reset request. An access to an offset with no register returns zero and raises a one-cycle error pulse. These three outputs come from an event state machine with states EV_IDLE, EV_SHUTDOWN, EV_RESET and EV_BADADDR. Each cycle it moves to the state named by the current access, and to EV_IDLE when the access has no side effect. If a read and a write arrive in the same cycle, the write's event wins.

The write lock is a two-state machine. It leaves LK_OPEN for LK_SET on any write to its offset, whatever the data, and stays in LK_SET until reset.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset the registers read as follows. System ID reads 0x10014D31, clock frequency reads 80000000 (0x04C4B400), capabilities read 0, the command register reads 0x1, and the write lock, GPIO output, GPIO interrupt enable and scratchpad read 0. All request and error outputs are low.
- R2: The word index is byte address bits [6:2], and bits [1:0] are ignored. `rd_data` is loaded at the clock edge where `rd_en` is high, and it holds that value until the next read.
- R3: The GPIO input register (word 0) holds the strapping value 1 during reset. After that it loads `gpio_in` at every clock edge, and it reads back zero-extended to 32 bits.
- R4: The GPIO output register (word 1) and the interrupt-enable register (word 2) store the low GPIO_W bits of the write data. They read back zero-extended and drive `gpio_out` and `gpio_irq_en` directly.
- R5: The scratchpad (word 20) stores and returns all 32 bits.
- R6: A write to the command register (word 16) whose data bits [15:0] equal 0x000E sets `shutdown_req` high for exactly the cycle after the write. Any other data gives no pulse. The command register always reads 0x1 (ready).
- R7: Any write to the write lock (word 21) makes it read 1, even when the data is zero. It stays 1 until reset.
- R8: A write to the system ID (word 31) leaves its value unchanged and sets `reset_req` high for exactly the cycle after the write.
- R9: Writes to words 0, 29 and 30 are ignored and raise no error.
- R10: Words 4–6 belong to timer channel 0 and words 8–10 to channel 1. During a write to a timer word, `tmr_wr` has the bit of that channel set in the same cycle, and `tmr_sel` gives the sub-register (0, 1, 2). A read of a timer word returns the channel's 32-bit slice of `tmr_rdata`.
- R11: A read or write of an unmapped word (for example 3, 7 or 22) returns 0, changes no register, and sets `bad_addr` high for the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| gpio_in | input | GPIO_W | GPIO input pins |
| gpio_out | output | GPIO_W | GPIO output pins |
| gpio_irq_en | output | GPIO_W | Per-pin interrupt enable to external logic |
| tmr_wr | output | 2 | Per-channel timer write strobe |
| tmr_sel | output | 2 | Timer sub-register select |
| tmr_rdata | input | 64 | Timer read data, channel 1 in the upper word |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |
| bad_addr | output | 1 | One-cycle unmapped-access pulse |

## Verification
The command register is written with the exact shutdown code, with the code carrying set upper bits, and with a near-miss value. These separate a match on the low half-word from a full-word match or a loose compare. The write lock is written with zero and then with all ones, which shows that the data is ignored. The GPIO registers are written with values wider than the pin count, which exposes wrong truncation or zero-extension. Accesses to timer, read-only, identifier and unmapped offsets, plus an address with its low bits set, tell apart decode errors at the window edges, word-index shifting, and which side-effect pulse fires.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 5;
    localparam int NUM_TMR    = 2;
    localparam int TMR_BASE0  = 4;
    localparam int TMR_STRIDE = 4;
    localparam int TMR_REGS   = 3;

    localparam logic [IDX_W-1:0] OFS_GPIO_IN  = 5'd0;
    localparam logic [IDX_W-1:0] OFS_GPIO_OUT = 5'd1;
    localparam logic [IDX_W-1:0] OFS_GPIO_IEN = 5'd2;
    localparam logic [IDX_W-1:0] OFS_CMD      = 5'd16;
    localparam logic [IDX_W-1:0] OFS_SCRATCH  = 5'd20;
    localparam logic [IDX_W-1:0] OFS_LOCK     = 5'd21;
    localparam logic [IDX_W-1:0] OFS_FREQ     = 5'd29;
    localparam logic [IDX_W-1:0] OFS_CAPS     = 5'd30;
    localparam logic [IDX_W-1:0] OFS_SYSID    = 5'd31;

    typedef enum logic [3:0] {
        K_NONE, K_GPIO_IN, K_GPIO_OUT, K_GPIO_IEN, K_TIMER,
        K_CMD, K_SCRATCH, K_LOCK, K_FREQ, K_CAPS, K_SYSID
    } reg_kind_e;

    typedef enum logic {LK_OPEN, LK_SET} lock_state_e;

    typedef enum logic [1:0] {EV_IDLE, EV_SHUTDOWN, EV_RESET, EV_BADADDR} event_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output reg_kind_e          kind,
    output logic [NUM_TMR-1:0] tmr_hit,
    output logic [1:0]         tmr_sub
);
    for (genvar ch = 0; ch < NUM_TMR; ch++) begin : g_tmr_win
        localparam logic [IDX_W-1:0] LO = IDX_W'(TMR_BASE0 + ch * TMR_STRIDE);
        localparam logic [IDX_W-1:0] HI = IDX_W'(TMR_BASE0 + ch * TMR_STRIDE + TMR_REGS - 1);
        assign tmr_hit[ch] = (idx >= LO) && (idx <= HI);
    end

    // windows are aligned to the stride, so the low bits select the register
    assign tmr_sub = idx[1:0];

    always_comb begin
        kind = K_NONE;
        if (|tmr_hit) begin
            kind = K_TIMER;
        end else begin
            unique case (idx)
                OFS_GPIO_IN:  kind = K_GPIO_IN;
                OFS_GPIO_OUT: kind = K_GPIO_OUT;
                OFS_GPIO_IEN: kind = K_GPIO_IEN;
                OFS_CMD:      kind = K_CMD;
                OFS_SCRATCH:  kind = K_SCRATCH;
                OFS_LOCK:     kind = K_LOCK;
                OFS_FREQ:     kind = K_FREQ;
                OFS_CAPS:     kind = K_CAPS;
                OFS_SYSID:    kind = K_SYSID;
                default:      kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_lock_fsm.sv
module sysctl_lock_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    lock_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LK_OPEN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LK_OPEN: if (set_req) st_d = LK_SET;
            LK_SET:  st_d = LK_SET;
            default: st_d = LK_OPEN;
        endcase
    end

    always_comb locked = (st_q == LK_SET);

    // R7: once set, the flag never clears before reset
    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);
    // R7: the flag only rises after a lock write
    p_lock_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(set_req));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int          GPIO_W       = 8,
    parameter int          STRAP        = 1,
    parameter logic [31:0] FREQ_HZ      = 32'd80000000,
    parameter logic [31:0] CAPS         = 32'h0000_0000,
    parameter logic [31:0] SYS_ID       = 32'h1001_4D31,
    parameter logic [15:0] CMD_SHUTDOWN = 16'h000E
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W+1:0]          addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [WORD_W-1:0]         rd_data,
    input  logic [GPIO_W-1:0]         gpio_in,
    output logic [GPIO_W-1:0]         gpio_out,
    output logic [GPIO_W-1:0]         gpio_irq_en,
    output logic [NUM_TMR-1:0]        tmr_wr,
    output logic [1:0]                tmr_sel,
    input  logic [NUM_TMR*WORD_W-1:0] tmr_rdata,
    output logic                      shutdown_req,
    output logic                      reset_req,
    output logic                      bad_addr
);
    localparam int          BYTE_AW   = IDX_W + 2;
    localparam logic [31:0] CMD_READY = 32'h0000_0001;

    logic [IDX_W-1:0]   idx;
    reg_kind_e          kind;
    logic [NUM_TMR-1:0] tmr_hit;
    logic [1:0]         tmr_sub;
    logic               locked;

    logic [GPIO_W-1:0] gpio_in_q, gpio_out_q, gpio_ien_q;
    logic [WORD_W-1:0] scratch_q, rd_mux, rd_data_q, tmr_mux;
    event_e            ev_q, ev_d;

    assign idx = addr[BYTE_AW-1:2];

    sysctl_decode u_decode (
        .idx     (idx),
        .kind    (kind),
        .tmr_hit (tmr_hit),
        .tmr_sub (tmr_sub)
    );

    sysctl_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && (kind == K_LOCK)),
        .locked  (locked)
    );

    // storage registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpio_in_q  <= GPIO_W'(STRAP);
            gpio_out_q <= '0;
            gpio_ien_q <= '0;
            scratch_q  <= '0;
        end else begin
            gpio_in_q <= gpio_in;
            if (wr_en) begin
                case (kind)
                    K_GPIO_OUT: gpio_out_q <= wr_data[GPIO_W-1:0];
                    K_GPIO_IEN: gpio_ien_q <= wr_data[GPIO_W-1:0];
                    K_SCRATCH:  scratch_q  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // timer read-data select
    always_comb begin
        tmr_mux = '0;
        for (int ch = 0; ch < NUM_TMR; ch++) begin
            if (tmr_hit[ch]) tmr_mux = tmr_rdata[ch*WORD_W +: WORD_W];
        end
    end

    always_comb begin
        unique case (kind)
            K_GPIO_IN:  rd_mux = WORD_W'(gpio_in_q);
            K_GPIO_OUT: rd_mux = WORD_W'(gpio_out_q);
            K_GPIO_IEN: rd_mux = WORD_W'(gpio_ien_q);
            K_TIMER:    rd_mux = tmr_mux;
            K_CMD:      rd_mux = CMD_READY;
            K_SCRATCH:  rd_mux = scratch_q;
            K_LOCK:     rd_mux = WORD_W'(locked);
            K_FREQ:     rd_mux = FREQ_HZ;
            K_CAPS:     rd_mux = CAPS;
            K_SYSID:    rd_mux = SYS_ID;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data_q <= '0;
        else if (rd_en) rd_data_q <= rd_mux;
    end

    // event state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= EV_IDLE;
        else        ev_q <= ev_d;
    end

    // event state machine: next state
    always_comb begin
        ev_d = EV_IDLE;
        if (wr_en) begin
            unique case (kind)
                K_CMD:   if (wr_data[15:0] == CMD_SHUTDOWN) ev_d = EV_SHUTDOWN;
                K_SYSID: ev_d = EV_RESET;
                K_NONE:  ev_d = EV_BADADDR;
                default: ev_d = EV_IDLE;
            endcase
        end else if (rd_en && (kind == K_NONE)) begin
            ev_d = EV_BADADDR;
        end
    end

    // event state machine: outputs
    always_comb begin
        shutdown_req = 1'b0;
        reset_req    = 1'b0;
        bad_addr     = 1'b0;
        unique case (ev_q)
            EV_SHUTDOWN: shutdown_req = 1'b1;
            EV_RESET:    reset_req    = 1'b1;
            EV_BADADDR:  bad_addr     = 1'b1;
            default: ;
        endcase
    end

    assign rd_data     = rd_data_q;
    assign gpio_out    = gpio_out_q;
    assign gpio_irq_en = gpio_ien_q;
    assign tmr_wr      = wr_en ? tmr_hit : '0;
    assign tmr_sel     = tmr_sub;

    // R11: at most one side-effect pulse per cycle
    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shutdown_req, reset_req, bad_addr}));
    // R6: shutdown only follows a matching command write
    p_shutdown_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> ($past(wr_en) && ($past(idx) == OFS_CMD)
                          && ($past(wr_data[15:0]) == CMD_SHUTDOWN)));
    // R8: reset request only follows an identifier write
    p_reset_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> ($past(wr_en) && ($past(idx) == OFS_SYSID)));
    // R8: identifier reads back its constant
    p_sysid_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (idx == OFS_SYSID)) |=> (rd_data == SYS_ID));
    // R10: at most one timer channel strobed
    p_tmr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_wr));
    // R11: unmapped reads return zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (kind == K_NONE)) |=> (rd_data == '0));
endmodule

// File: tb/sysctl_regbank_bench.sv
module sysctl_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  gpio_in = 8'hA5;
    logic [7:0]  gpio_out, gpio_irq_en;
    logic [1:0]  tmr_wr, tmr_sel;
    logic [63:0] tmr_rdata = {32'h2222_1111, 32'h0000_ABCD};
    logic        shutdown_req, reset_req, bad_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic sd_s, rs_s, ba_s;
    logic [31:0] rv;

    always #5 clk = ~clk;

    sysctl_regbank u_sysctl_regbank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_irq_en(gpio_irq_en), .tmr_wr(tmr_wr),
        .tmr_sel(tmr_sel), .tmr_rdata(tmr_rdata), .shutdown_req(shutdown_req),
        .reset_req(reset_req), .bad_addr(bad_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        sd_s = shutdown_req; rs_s = reset_req; ba_s = bad_addr;
    endtask

    task automatic do_read(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        sd_s = shutdown_req; rs_s = reset_req; ba_s = bad_addr;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; addr = 7'h00; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R3 strap value", rd_data, 32'h1);
        chk("R1 outputs low", {29'b0, shutdown_req, reset_req, bad_addr}, 32'h0);
        chk("R1 gpio_out port", 32'(gpio_out), 32'h0);
        do_read(7'd124, rv); chk("R1 system id", rv, 32'h1001_4D31);
        do_read(7'd116, rv); chk("R1 clock freq", rv, 32'h04C4_B400);
        do_read(7'd120, rv); chk("R1 capabilities", rv, 32'h0);
        do_read(7'd64, rv);  chk("R1 command ready", rv, 32'h1);
        do_read(7'd84, rv);  chk("R1 lock clear", rv, 32'h0);
        do_read(7'd80, rv);  chk("R1 scratch zero", rv, 32'h0);
        do_read(7'd8, rv);   chk("R1 irq enable zero", rv, 32'h0);
    endtask

    task automatic t_gpio;
        gpio_in = 8'h3C;
        repeat (2) @(negedge clk);
        do_read(7'd0, rv); chk("R3 gpio in tracks pins", rv, 32'h3C);
        do_write(7'd4, 32'h0000_01FF);
        chk("R4 gpio_out port", 32'(gpio_out), 32'hFF);
        do_read(7'd4, rv); chk("R4 gpio out readback", rv, 32'hFF);
        do_write(7'd8, 32'hFFFF_FF5A);
        chk("R4 irq enable port", 32'(gpio_irq_en), 32'h5A);
        do_read(7'd8, rv); chk("R4 irq enable readback", rv, 32'h5A);
    endtask

    task automatic t_scratch;
        do_write(7'h50, 32'hDEAD_BEEF);
        do_read(7'h53, rv); chk("R2 R5 scratch via unaligned byte addr", rv, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R2 rd_data holds", rd_data, 32'hDEAD_BEEF);
        do_write(7'h52, 32'h0123_4567);
        do_read(7'h50, rv); chk("R5 scratch rewrite", rv, 32'h0123_4567);
    endtask

    task automatic t_cmd;
        do_write(7'd64, 32'h0000_000E);
        chk("R6 shutdown pulse", 32'(sd_s), 32'h1);
        @(negedge clk);
        chk("R6 shutdown one cycle", 32'(shutdown_req), 32'h0);
        do_write(7'd64, 32'h0001_000E);
        chk("R6 shutdown upper bits ignored", 32'(sd_s), 32'h1);
        do_write(7'd64, 32'h0000_000F);
        chk("R6 near miss no pulse", 32'(sd_s), 32'h0);
        do_read(7'd64, rv); chk("R6 command reads ready", rv, 32'h1);
    endtask

    task automatic t_lock;
        do_write(7'd84, 32'h0);
        do_read(7'd84, rv); chk("R7 lock set by zero write", rv, 32'h1);
        do_write(7'd84, 32'hFFFF_FFFF);
        do_read(7'd84, rv); chk("R7 lock stays 1", rv, 32'h1);
    endtask

    task automatic t_sysid;
        do_write(7'd124, 32'h0);
        chk("R8 reset pulse", 32'(rs_s), 32'h1);
        chk("R8 no error", 32'(ba_s), 32'h0);
        @(negedge clk);
        chk("R8 reset one cycle", 32'(reset_req), 32'h0);
        do_read(7'd124, rv); chk("R8 id unchanged", rv, 32'h1001_4D31);
    endtask

    task automatic t_readonly;
        do_write(7'd0, 32'hFFFF_FFFF);
        chk("R9 gpio in write no error", 32'(ba_s), 32'h0);
        do_write(7'd116, 32'hFFFF_FFFF);
        chk("R9 freq write no error", 32'(ba_s), 32'h0);
        do_write(7'd120, 32'hFFFF_FFFF);
        do_read(7'd116, rv); chk("R9 freq unchanged", rv, 32'h04C4_B400);
        do_read(7'd120, rv); chk("R9 caps unchanged", rv, 32'h0);
        do_read(7'd0, rv);   chk("R9 gpio in still pins", rv, 32'h3C);
    endtask

    task automatic t_timer;
        @(negedge clk);
        addr = 7'h14; wr_data = 32'h55; wr_en = 1'b1;
        #1;
        chk("R10 ch0 strobe", 32'(tmr_wr), 32'h1);
        chk("R10 ch0 compare select", 32'(tmr_sel), 32'h1);
        @(negedge clk);
        addr = 7'h28;
        #1;
        chk("R10 ch1 strobe", 32'(tmr_wr), 32'h2);
        chk("R10 ch1 counter select", 32'(tmr_sel), 32'h2);
        @(negedge clk);
        addr = 7'h1C;
        #1;
        chk("R10 gap no strobe", 32'(tmr_wr), 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        do_read(7'h18, rv); chk("R10 ch0 read", rv, 32'h0000_ABCD);
        do_read(7'h20, rv); chk("R10 ch1 read", rv, 32'h2222_1111);
    endtask

    task automatic t_unmapped;
        do_write(7'h0C, 32'h5555_5555);
        chk("R11 write error pulse", 32'(ba_s), 32'h1);
        @(negedge clk);
        chk("R11 error one cycle", 32'(bad_addr), 32'h0);
        do_read(7'h0C, rv); chk("R11 read zero", rv, 32'h0);
        chk("R11 read error pulse", 32'(ba_s), 32'h1);
        do_write(7'd88, 32'h7777_7777);
        do_read(7'd88, rv); chk("R11 word 22 zero", rv, 32'h0);
        do_read(7'h50, rv); chk("R11 scratch untouched", rv, 32'h0123_4567);
        chk("R11 gpio_out untouched", 32'(gpio_out), 32'hFF);
    endtask

    initial begin
        t_reset;
        t_gpio;
        t_scratch;
        t_cmd;
        t_lock;
        t_sysid;
        t_readonly;
        t_timer;
        t_unmapped;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule